// File: doc/BRIEF.md
# Shared Bus Tenure Controller

This block is the per-master state machine that wins, holds and gives back ownership of an external bus shared by several masters. An external arbiter answers the block's request with a grant. The block then waits until the previous owner has left the bus, and only then takes the bus by raising its acknowledge. Acknowledge also tells the local bus-cycle engine that transfers may start.

Once it owns the bus, the block keeps it for as long as the grant stays high, even when it has no work left. This is bus parking: the master can reuse the bus without arbitrating again. When the grant is withdrawn, ownership is handed back only at a clean boundary. That boundary is the end of the access in flight or, for an indivisible read-modify-write, the end of the whole read-then-write pair. A lock output marks the atomic sequence for external memories.

Handing back the bus passes through one drive-high cycle before the slave state. In that cycle the pad logic can actively pull the open-drain acknowledge line high before it floats it.

States and transitions:
- SLAVE: leaves for PENDING on grant.
- PENDING: returns to SLAVE if grant drops. Moves to MASTER when grant is high and busy is low.
- MASTER: moves to RELEASE when grant is low, no read-modify-write is active, and either no access is pending or the current access ends this cycle.
- RELEASE: always moves to SLAVE after one cycle.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: `bus_req` is a register that, one clock after each edge, equals `xfer_pending OR req_hold` as sampled at that edge.
- R2: From SLAVE, a high `bus_grant` moves the block to PENDING at the next edge. Neither SLAVE nor PENDING drives `bus_ack`.
- R3: In PENDING, the block moves to MASTER at the next edge when `bus_grant` is high and `bus_busy` is low. If `bus_grant` is low it returns to SLAVE. Otherwise it stays in PENDING.
- R4: `bus_owned` is high exactly when `bus_ack` is high.
- R5: In MASTER with `bus_grant` high, the block stays in MASTER whatever the values of `xfer_pending`, `req_hold` and `bus_req` (parking).
- R6: In MASTER with `bus_grant` low, the block stays in MASTER while `xfer_pending` is high and `seq_done` is low.
- R7: In MASTER, the block stays in MASTER while `rmw_active` is high, even with `bus_grant` low and `seq_done` pulsing between the read and the write.
- R8: In MASTER, the block enters RELEASE when `bus_grant` is low, `rmw_active` is low, and either `xfer_pending` is low or `seq_done` is high. While in RELEASE, `ack_drive_hi` is high and `bus_ack` is low. After exactly one cycle the block goes to SLAVE.
- R9: `bus_lock` is a register that, one clock after each edge, equals `rmw_active OR lock_hold` as sampled at that edge.
- R10: While `rst_n` is low, the block is in SLAVE and `bus_req`, `bus_lock`, `bus_ack`, `ack_drive_hi` and `bus_owned` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_pending | input | 1 | An external access is waiting or in progress |
| seq_done | input | 1 | Pulse: the current external access ends this cycle |
| req_hold | input | 1 | Control bit forcing the request high |
| lock_hold | input | 1 | Control bit forcing the lock high |
| rmw_active | input | 1 | Indivisible read-modify-write, high from the read start to the write end |
| bus_grant | input | 1 | Arbiter grant, active high, synchronous |
| bus_busy | input | 1 | Some master owns the bus, active high, synchronous |
| bus_req | output | 1 | Request to the arbiter |
| bus_ack | output | 1 | Ownership acknowledge |
| ack_drive_hi | output | 1 | One-cycle active pull-up phase after the acknowledge drops |
| bus_lock | output | 1 | Atomic-sequence lock |
| bus_owned | output | 1 | Status: block is bus master, transfers may start |

## Verification
The properties assume that grant and busy change only in step with the clock. They also assume that every input is held low while reset is active, so that the registered request and lock follow their inputs from the first live edge. The bench drives every input on the falling edge and keeps all of them at zero through reset. It forms the busy input as the OR of the other masters' busy and the block's own acknowledge, as a shared wired line would. This means busy can drop only while the block is not yet the owner.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;

    typedef enum logic [1:0] {
        ST_SLAVE   = 2'd0,
        ST_PENDING = 2'd1,
        ST_MASTER  = 2'd2,
        ST_RELEASE = 2'd3
    } tenure_state_e;

endpackage

// File: rtl/bus_hold_eval.sv
// Decides when ownership may be taken and when it may be handed back.
module bus_hold_eval (
    input  logic xfer_pending,
    input  logic seq_done,
    input  logic rmw_active,
    input  logic bus_grant,
    input  logic bus_busy,
    output logic may_take,
    output logic may_drop
);
    logic access_open;

    always_comb begin
        // an access still in flight that does not end this cycle
        access_open = xfer_pending && !seq_done;
        may_take    = bus_grant && !bus_busy;
        may_drop    = !bus_grant && !rmw_active && !access_open;
    end
endmodule

// File: rtl/bus_tenure_fsm.sv
module bus_tenure_fsm
    import bus_tenure_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_grant,
    input  logic          may_take,
    input  logic          may_drop,
    output tenure_state_e state,
    output logic          ack,
    output logic          drive_hi,
    output logic          owned
);
    tenure_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLAVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLAVE:   if (bus_grant) state_nx = ST_PENDING;
            ST_PENDING: begin
                if (!bus_grant)    state_nx = ST_SLAVE;
                else if (may_take) state_nx = ST_MASTER;
            end
            ST_MASTER:  if (may_drop) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_SLAVE;
            default:    state_nx = ST_SLAVE;
        endcase
    end

    always_comb begin
        ack      = 1'b0;
        drive_hi = 1'b0;
        owned    = 1'b0;
        unique case (state)
            ST_MASTER: begin
                ack   = 1'b1;
                owned = 1'b1;
            end
            ST_RELEASE: drive_hi = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_sig_reg.sv
// Registered request and lock lines.
module bus_sig_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_pending,
    input  logic req_hold,
    input  logic rmw_active,
    input  logic lock_hold,
    output logic bus_req,
    output logic bus_lock
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req  <= 1'b0;
            bus_lock <= 1'b0;
        end else begin
            bus_req  <= xfer_pending | req_hold;
            bus_lock <= rmw_active | lock_hold;
        end
    end
endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
    import bus_tenure_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_pending,
    input  logic seq_done,
    input  logic req_hold,
    input  logic lock_hold,
    input  logic rmw_active,
    input  logic bus_grant,
    input  logic bus_busy,
    output logic bus_req,
    output logic bus_ack,
    output logic ack_drive_hi,
    output logic bus_lock,
    output logic bus_owned
);
    logic          may_take;
    logic          may_drop;
    tenure_state_e state;

    bus_hold_eval u_eval (
        .xfer_pending (xfer_pending),
        .seq_done     (seq_done),
        .rmw_active   (rmw_active),
        .bus_grant    (bus_grant),
        .bus_busy     (bus_busy),
        .may_take     (may_take),
        .may_drop     (may_drop)
    );

    bus_tenure_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_grant (bus_grant),
        .may_take  (may_take),
        .may_drop  (may_drop),
        .state     (state),
        .ack       (bus_ack),
        .drive_hi  (ack_drive_hi),
        .owned     (bus_owned)
    );

    bus_sig_reg u_sig (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_pending (xfer_pending),
        .req_hold     (req_hold),
        .rmw_active   (rmw_active),
        .lock_hold    (lock_hold),
        .bus_req      (bus_req),
        .bus_lock     (bus_lock)
    );
endmodule

// File: rtl/bus_tenure_chk.sv
module bus_tenure_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_pending,
    input logic seq_done,
    input logic req_hold,
    input logic lock_hold,
    input logic rmw_active,
    input logic bus_grant,
    input logic bus_busy,
    input logic bus_req,
    input logic bus_ack,
    input logic ack_drive_hi,
    input logic bus_lock,
    input logic bus_owned
);
    // high once at least one live edge has passed since reset
    logic live;
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    p_req_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> bus_req == ($past(xfer_pending) | $past(req_hold)));

    p_lock_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> bus_lock == ($past(rmw_active) | $past(lock_hold)));

    p_take_needs_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(bus_ack)) |-> ($past(bus_grant) && !$past(bus_busy)));

    p_status_matches_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_owned == bus_ack);

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_grant) |=> bus_ack);

    p_mid_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && xfer_pending && !seq_done) |=> bus_ack);

    p_rmw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && rmw_active) |=> bus_ack);

    p_pullup_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive_hi |=> (!ack_drive_hi && !bus_ack));

    p_drop_via_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $fell(bus_ack)) |-> ack_drive_hi);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_drive_hi && bus_ack));
endmodule

bind bus_tenure_ctrl bus_tenure_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_pending (xfer_pending),
    .seq_done     (seq_done),
    .req_hold     (req_hold),
    .lock_hold    (lock_hold),
    .rmw_active   (rmw_active),
    .bus_grant    (bus_grant),
    .bus_busy     (bus_busy),
    .bus_req      (bus_req),
    .bus_ack      (bus_ack),
    .ack_drive_hi (ack_drive_hi),
    .bus_lock     (bus_lock),
    .bus_owned    (bus_owned)
);

// File: tb/bus_tenure_ctrl_test.sv
`timescale 1ns/1ps
module bus_tenure_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pend = 1'b0, done = 1'b0, rh = 1'b0, lh = 1'b0, rmw = 1'b0;
    logic gnt = 1'b0, other_busy = 1'b0;
    logic busy;
    logic o_req, o_ack, o_drv, o_lock, o_own;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    assign busy = other_busy | o_ack;

    bus_tenure_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .xfer_pending (pend), .seq_done (done), .req_hold (rh),
        .lock_hold (lh), .rmw_active (rmw),
        .bus_grant (gnt), .bus_busy (busy),
        .bus_req (o_req), .bus_ack (o_ack), .ack_drive_hi (o_drv),
        .bus_lock (o_lock), .bus_owned (o_own)
    );

    // behavioural reference: 0 slave, 1 waiting, 2 owner, 3 pull-up
    int    m_st = 0;
    bit    m_req = 0, m_lock = 0;
    string m_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_req = 0; m_lock = 0; m_tag = "R10";
        end else begin
            bit in_busy;
            in_busy = other_busy | (m_st == 2);
            m_req  = pend | rh;
            m_lock = rmw | lh;
            if (m_st == 0) begin
                m_tag = "R2";
                if (gnt) m_st = 1;
            end else if (m_st == 1) begin
                m_tag = "R3";
                if (!gnt) m_st = 0;
                else if (!in_busy) m_st = 2;
            end else if (m_st == 2) begin
                if (gnt) m_tag = "R5";
                else if (rmw) m_tag = "R7";
                else if (pend && !done) m_tag = "R6";
                else begin m_tag = "R8"; m_st = 3; end
            end else begin
                m_tag = "R8";
                m_st = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", o_req, m_req);
        chk("R9", o_lock, m_lock);
        chk(m_tag, o_ack, m_st == 2);
        chk("R8", o_drv, m_st == 3);
        chk("R4", o_own, o_ack);
    endtask

    // compare on the falling edge, then drive the next inputs
    task automatic cyc(input logic p, input logic d, input logic r_h,
                       input logic l_h, input logic rm, input logic g,
                       input logic ob);
        @(negedge clk);
        compare_all();
        pend = p; done = d; rh = r_h; lh = l_h; rmw = rm; gnt = g; other_busy = ob;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        chk("R10", o_req, 1'b0);
        chk("R10", o_ack, 1'b0);
        chk("R10", o_drv, 1'b0);
        chk("R10", o_lock, 1'b0);
        chk("R10", o_own, 1'b0);
        rst_n = 1'b1;
        repeat (2) cyc(0,0,0,0,0,0,0);
        // R1: request from pending work; R2/R3: grant while another master is on the bus
        cyc(1,0,0,0,0,0,0);
        cyc(1,0,0,0,0,1,1);
        repeat (4) cyc(1,0,0,0,0,1,1);
        // R3: previous owner leaves, ownership taken
        cyc(1,0,0,0,0,1,0);
        repeat (2) cyc(1,0,0,0,0,1,0);
        cyc(1,1,0,0,0,1,0);
        // R5: parking with no work and no request
        repeat (5) cyc(0,0,0,0,0,1,0);
        // R1: request held by control bit
        repeat (3) cyc(0,0,1,0,0,1,0);
        // R6: grant withdrawn mid-access
        cyc(1,0,0,0,0,1,0);
        repeat (3) cyc(1,0,0,0,0,0,0);
        // R8: access ends, release then slave
        cyc(1,1,0,0,0,0,0);
        repeat (3) cyc(0,0,0,0,0,0,0);
        // re-acquire
        cyc(0,0,0,0,0,1,0);
        repeat (2) cyc(1,0,0,0,0,1,0);
        // R7/R9: atomic sequence with grant removed
        cyc(1,0,0,0,1,1,0);
        repeat (2) cyc(1,0,0,0,1,0,0);
        cyc(1,1,0,0,1,0,0);          // read ends
        repeat (2) cyc(1,0,0,0,1,0,0);
        cyc(1,1,0,0,1,0,0);          // write ends
        cyc(0,0,0,0,0,0,0);          // R8 release
        repeat (3) cyc(0,0,0,0,0,0,0);
        // R3: grant vanishes while waiting
        cyc(1,0,0,0,0,1,1);
        cyc(1,0,0,0,0,1,1);
        cyc(1,0,0,0,0,0,1);
        // R9: lock held by control bit
        repeat (3) cyc(0,0,0,1,0,0,0);
        repeat (2) cyc(0,0,0,0,0,0,0);
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic p, d, r_h, l_h, rm, g, ob;
            p   = ($urandom % 3) != 0;
            d   = p && (($urandom % 4) == 0);
            r_h = ($urandom % 8) == 0;
            l_h = ($urandom % 8) == 0;
            rm  = ($urandom % 4) == 0;
            g   = ($urandom % 4) != 0;
            ob  = ($urandom % 3) == 0;
            cyc(p, d, r_h, l_h, rm, g, ob);
        end
        cyc(0,0,0,0,0,0,0);
        @(negedge clk);
        compare_all();
        finish_run();
    end
endmodule